// File: doc/BRIEF.md
# Global Power Mode Sequencer

This controller holds the chip-wide power mode: Active, Alternate Active, Sleep or Hibernate. It keeps two firmware-written enable templates, one used in Active and one in Alternate Active. Each template has one bit per subsystem, and bit 0 of each is the CPU. In either running mode the chosen template drives the subsystem clock enables and the CPU enable directly. In Sleep and Hibernate every enable is held low.

Firmware moves between modes with a request strobe. Leaving a low-power mode takes a wakeup event. In Sleep any of four sources counts: internal interrupt, supply supervisor, periodic tick, or external I/O interrupt. In Hibernate only the external I/O interrupt counts. A wakeup always brings the mode back to Active and sets the CPU bit of the Active template. The controller then counts a resume delay in pulses of a reference tick. The delay is separate for Sleep and for Hibernate, and the ready flag stays low until it has run out. Power-on reset, the external reset pin and a watchdog reset all return the block to Active with ready high.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset, or one cycle after `xres_i` or `wdt_rst_i` is high at a clock edge, `mode_o` is 2'b00 and `ready_o` is 1. Both templates return to their reset values: Active all ones, Alternate `8'hFC`, which has CPU bit 0 and flash bit 1 clear.
- R2: In Active (`mode_o` 2'b00) with `ready_o` high, `sub_en_o[i]` equals Active template bit i+1 and `cpu_en_o` equals bit 0. A write (`tmpl_we_i`, `tmpl_sel_i`=0) shows on the outputs in the cycle after the write edge.
- R3: In Alternate Active (2'b01), the enables come from the Alternate template in the same way. A write with `tmpl_sel_i`=1 updates that template.
- R4: While running, a request sets `mode_o` to `req_mode_i` at the next edge. The codes are 00 Active, 01 Alternate Active, 10 Sleep and 11 Hibernate. In Sleep and Hibernate, `ready_o`, `cpu_en_o` and every `sub_en_o` bit are 0.
- R5: In Sleep, any one of `wake_int_i`, `wake_sup_i`, `wake_tick_i` or `wake_io_i` sets `mode_o` to 2'b00 at the next edge, with `ready_o` still 0. Mode requests made while in Sleep or Hibernate are ignored.
- R6: In Hibernate, `wake_int_i`, `wake_sup_i` and `wake_tick_i` have no effect and `mode_o` stays 2'b11. Only `wake_io_i` wakes the block.
- R7: After a wakeup, `ready_o` rises one cycle after the N-th edge that samples `ref_tick_i` high. N is `SLP_TICKS` (default 15) when waking from Sleep and `HIB_TICKS` (default 99) when waking from Hibernate. Until then all enables are 0.
- R8: A wakeup event sets bit 0 of the Active template. This happens in any state except a running resume, and it applies even if firmware had cleared that bit. A wakeup in Alternate Active switches the mode to Active with no delay.
- R9: A request that arrives while the resume delay is running is held. `mode_o` stays 2'b00 until `ready_o` rises. The held request takes effect at the next edge after that.
- R10: While running, a wakeup that arrives in the same cycle as a Sleep or Hibernate request wins: `mode_o` becomes or stays 2'b00 and `ready_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| xres_i | input | 1 | External reset pin, synchronous, active high |
| wdt_rst_i | input | 1 | Watchdog reset, synchronous, active high |
| ref_tick_i | input | 1 | One pulse per reference clock period, paces resume delays |
| req_valid_i | input | 1 | Mode change request strobe |
| req_mode_i | input | 2 | Requested mode code |
| tmpl_we_i | input | 1 | Template write strobe |
| tmpl_sel_i | input | 1 | Template select: 0 Active, 1 Alternate |
| tmpl_wdata_i | input | N_SUB | Template write data, bit 0 is CPU |
| wake_int_i | input | 1 | Internal interrupt wakeup |
| wake_sup_i | input | 1 | Supply supervisor wakeup |
| wake_tick_i | input | 1 | Periodic tick wakeup |
| wake_io_i | input | 1 | External I/O interrupt wakeup |
| mode_o | output | 2 | Current global mode code |
| sub_en_o | output | N_SUB-1 | Gated clock enables for subsystems 1..N_SUB-1 |
| cpu_en_o | output | 1 | CPU enable |
| ready_o | output | 1 | High when running and any resume delay has ended |

## Verification
A wrong sequencer state shows at the ports at once. A mode code that disagrees with the enables, or a ready flag that does not match the code, is visible in the same cycle. A wakeup source taken when it should not be, or missed when it should be taken, moves `mode_o` one edge after the pulse. A faulty resume counter shows only when `ready_o` rises: it rises one tick early or late against the parameter count, and a held request then moves the mode one edge late. A lost CPU override stays hidden until the delay ends, when `cpu_en_o` comes up low.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_ACT = 2'b00,
    PM_ALT = 2'b01,
    PM_SLP = 2'b10,
    PM_HIB = 2'b11
  } pm_mode_e;

  typedef enum logic [1:0] {
    PH_RUN = 2'b00,
    PH_LOW = 2'b01,
    PH_RES = 2'b10
  } pm_phase_e;

  localparam int unsigned NUM_WAKE = 4;
  localparam int unsigned WK_INT  = 0;
  localparam int unsigned WK_SUP  = 1;
  localparam int unsigned WK_TICK = 2;
  localparam int unsigned WK_IO   = 3;

  // Sources allowed to wake the chip for a given mode
  function automatic logic [NUM_WAKE-1:0] wake_mask(pm_mode_e m);
    logic [NUM_WAKE-1:0] msk;
    msk = '1;
    if (m == PM_HIB) begin
      msk = '0;
      msk[WK_IO] = 1'b1;
    end
    return msk;
  endfunction

  function automatic logic is_low_power(pm_mode_e m);
    return (m == PM_SLP) || (m == PM_HIB);
  endfunction

endpackage

// File: rtl/pm_wake_qual.sv
module pm_wake_qual
  import pwr_mode_pkg::*;
(
  input  logic [NUM_WAKE-1:0] src_i,
  input  pm_mode_e            mode_i,
  output logic                wake_o
);

  logic [NUM_WAKE-1:0] msk;
  logic [NUM_WAKE-1:0] hit;

  assign msk = wake_mask(mode_i);

  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_src
    assign hit[g] = src_i[g] & msk[g];
  end

  assign wake_o = |hit;

endmodule

// File: rtl/pm_resume_timer.sv
module pm_resume_timer #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          tick_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;
  logic          busy;

  assign busy   = (cnt_q != '0);
  assign done_o = busy && tick_i && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i;
    end else if (busy && tick_i) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R7: a new delay is only started once the previous one has ended
  p_load_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (cnt_q == '0));

  // R7: the count only moves on reference ticks
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_i && !load_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pm_tmpl_bank.sv
module pm_tmpl_bank #(
  parameter int unsigned N_SUB   = 8,
  parameter logic [N_SUB-1:0] ACT_RST = '1,
  parameter logic [N_SUB-1:0] ALT_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_rst_i,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [N_SUB-1:0] wdata_i,
  input  logic             wake_evt_i,
  output logic [N_SUB-1:0] act_o,
  output logic [N_SUB-1:0] alt_o
);

  logic [N_SUB-1:0] act_q, alt_q;
  logic [N_SUB-1:0] act_d, alt_d;

  always_comb begin
    act_d = act_q;
    alt_d = alt_q;
    if (we_i && !sel_i) act_d = wdata_i;
    if (we_i &&  sel_i) alt_d = wdata_i;
    // a wakeup re-enables the CPU regardless of what firmware wrote
    if (wake_evt_i) act_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= ACT_RST;
      alt_q <= ALT_RST;
    end else if (sync_rst_i) begin
      act_q <= ACT_RST;
      alt_q <= ALT_RST;
    end else begin
      act_q <= act_d;
      alt_q <= alt_d;
    end
  end

  assign act_o = act_q;
  assign alt_o = alt_q;

  // R8: the CPU bit is set after any wakeup event
  p_wake_cpu_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt_i && !sync_rst_i) |=> act_q[0]);

endmodule

// File: rtl/pm_seq_fsm.sv
module pm_seq_fsm
  import pwr_mode_pkg::*;
#(
  parameter int unsigned CW        = 7,
  parameter int unsigned SLP_TICKS = 15,
  parameter int unsigned HIB_TICKS = 99
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_rst_i,
  input  logic          req_valid_i,
  input  pm_mode_e      req_mode_i,
  input  logic          wake_hit_i,
  input  logic          timer_done_i,
  output pm_mode_e      mode_o,
  output logic          running_o,
  output logic          timer_load_o,
  output logic [CW-1:0] timer_len_o,
  output logic          wake_evt_o
);

  pm_phase_e ph_q, ph_d;
  pm_mode_e  mode_q, mode_d;
  logic      pend_v_q, pend_v_d;
  pm_mode_e  pend_m_q, pend_m_d;
  logic      eff_v;
  pm_mode_e  eff_m;

  function automatic logic [CW-1:0] resume_len(pm_mode_e m);
    return (m == PM_HIB) ? CW'(HIB_TICKS) : CW'(SLP_TICKS);
  endfunction

  assign eff_v       = req_valid_i | pend_v_q;
  assign eff_m       = req_valid_i ? req_mode_i : pend_m_q;
  assign timer_len_o = resume_len(mode_q);

  always_comb begin
    ph_d         = ph_q;
    mode_d       = mode_q;
    pend_v_d     = pend_v_q;
    pend_m_d     = pend_m_q;
    timer_load_o = 1'b0;
    wake_evt_o   = 1'b0;
    unique case (ph_q)
      PH_RUN: begin
        pend_v_d = 1'b0;
        if (wake_hit_i) begin
          mode_d     = PM_ACT;
          wake_evt_o = 1'b1;
        end else if (eff_v) begin
          mode_d = eff_m;
          if (is_low_power(eff_m)) ph_d = PH_LOW;
        end
      end
      PH_LOW: begin
        if (wake_hit_i) begin
          mode_d       = PM_ACT;
          ph_d         = PH_RES;
          timer_load_o = 1'b1;
          wake_evt_o   = 1'b1;
        end
      end
      PH_RES: begin
        if (req_valid_i) begin
          pend_v_d = 1'b1;
          pend_m_d = req_mode_i;
        end
        if (timer_done_i) ph_d = PH_RUN;
      end
      default: ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_RUN;
      mode_q   <= PM_ACT;
      pend_v_q <= 1'b0;
      pend_m_q <= PM_ACT;
    end else if (sync_rst_i) begin
      ph_q     <= PH_RUN;
      mode_q   <= PM_ACT;
      pend_v_q <= 1'b0;
      pend_m_q <= PM_ACT;
    end else begin
      ph_q     <= ph_d;
      mode_q   <= mode_d;
      pend_v_q <= pend_v_d;
      pend_m_q <= pend_m_d;
    end
  end

  assign mode_o    = mode_q;
  assign running_o = (ph_q == PH_RUN);

  // R9: the mode cannot leave Active while a resume delay is running
  p_hold_in_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RES) |=> (mode_q == PM_ACT));

  // R9: a request during the delay is remembered
  p_pend_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RES && req_valid_i && !sync_rst_i) |=> pend_v_q);

  // R7: the timer end returns the sequencer to running
  p_done_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_done_i && !sync_rst_i) |=> (ph_q == PH_RUN));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned N_SUB     = 8,
  parameter int unsigned SLP_TICKS = 15,
  parameter int unsigned HIB_TICKS = 99,
  parameter logic [N_SUB-1:0] ACT_RST = '1,
  parameter logic [N_SUB-1:0] ALT_RST = 8'hFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xres_i,
  input  logic             wdt_rst_i,
  input  logic             ref_tick_i,
  input  logic             req_valid_i,
  input  logic [1:0]       req_mode_i,
  input  logic             tmpl_we_i,
  input  logic             tmpl_sel_i,
  input  logic [N_SUB-1:0] tmpl_wdata_i,
  input  logic             wake_int_i,
  input  logic             wake_sup_i,
  input  logic             wake_tick_i,
  input  logic             wake_io_i,
  output logic [1:0]       mode_o,
  output logic [N_SUB-2:0] sub_en_o,
  output logic             cpu_en_o,
  output logic             ready_o
);

  localparam int unsigned MAX_TICKS = (SLP_TICKS > HIB_TICKS) ? SLP_TICKS : HIB_TICKS;
  localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

  logic                sync_rst;
  logic [NUM_WAKE-1:0] wake_src;
  logic                wake_hit;
  logic                wake_evt;
  logic                timer_load;
  logic                timer_done;
  logic [CW-1:0]       timer_len;
  logic                running;
  pm_mode_e            mode;
  logic [N_SUB-1:0]    act_tmpl, alt_tmpl, sel_tmpl;

  assign sync_rst = xres_i | wdt_rst_i;

  always_comb begin
    wake_src          = '0;
    wake_src[WK_INT]  = wake_int_i;
    wake_src[WK_SUP]  = wake_sup_i;
    wake_src[WK_TICK] = wake_tick_i;
    wake_src[WK_IO]   = wake_io_i;
  end

  pm_wake_qual u_wake (
    .src_i  (wake_src),
    .mode_i (mode),
    .wake_o (wake_hit)
  );

  pm_seq_fsm #(
    .CW        (CW),
    .SLP_TICKS (SLP_TICKS),
    .HIB_TICKS (HIB_TICKS)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_rst_i   (sync_rst),
    .req_valid_i  (req_valid_i),
    .req_mode_i   (pm_mode_e'(req_mode_i)),
    .wake_hit_i   (wake_hit),
    .timer_done_i (timer_done),
    .mode_o       (mode),
    .running_o    (running),
    .timer_load_o (timer_load),
    .timer_len_o  (timer_len),
    .wake_evt_o   (wake_evt)
  );

  pm_resume_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (sync_rst),
    .load_i (timer_load),
    .len_i  (timer_len),
    .tick_i (ref_tick_i),
    .done_o (timer_done)
  );

  pm_tmpl_bank #(
    .N_SUB   (N_SUB),
    .ACT_RST (ACT_RST),
    .ALT_RST (ALT_RST)
  ) u_tmpl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_rst_i (sync_rst),
    .we_i       (tmpl_we_i),
    .sel_i      (tmpl_sel_i),
    .wdata_i    (tmpl_wdata_i),
    .wake_evt_i (wake_evt),
    .act_o      (act_tmpl),
    .alt_o      (alt_tmpl)
  );

  assign sel_tmpl = (mode == PM_ALT) ? alt_tmpl : act_tmpl;

  for (genvar g = 0; g < N_SUB - 1; g++) begin : g_gate
    assign sub_en_o[g] = running & sel_tmpl[g+1];
  end

  assign cpu_en_o = running & sel_tmpl[0];
  assign mode_o   = mode;
  assign ready_o  = running;

  // R1: any synchronous reset lands in Active with ready high
  p_reset_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rst |=> (mode_o == PM_ACT && ready_o));

  // R4: low-power modes drive every enable low
  p_low_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_low_power(pm_mode_e'(mode_o)) |-> (sub_en_o == '0 && !cpu_en_o && !ready_o));

  // R6: hibernate is left only through the I/O interrupt or a reset
  p_hib_io_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_HIB && !wake_io_i && !sync_rst) |=> (mode_o == PM_HIB));

  // R5: a sleep wakeup forces Active on the next edge
  p_sleep_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_SLP && (wake_int_i || wake_sup_i || wake_tick_i || wake_io_i))
      |=> (mode_o == PM_ACT));

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;

  localparam int unsigned NS = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          xres, wdt, rtick, rv, twe, tsel;
  logic [1:0]    rm;
  logic [NS-1:0] twd;
  logic          w_int, w_sup, w_tick, w_io;
  logic [1:0]    mode;
  logic [NS-2:0] sub;
  logic          cpu, rdy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .xres_i(xres), .wdt_rst_i(wdt), .ref_tick_i(rtick),
    .req_valid_i(rv), .req_mode_i(rm), .tmpl_we_i(twe), .tmpl_sel_i(tsel),
    .tmpl_wdata_i(twd), .wake_int_i(w_int), .wake_sup_i(w_sup),
    .wake_tick_i(w_tick), .wake_io_i(w_io), .mode_o(mode), .sub_en_o(sub),
    .cpu_en_o(cpu), .ready_o(rdy)
  );

  typedef struct packed {
    logic       rv;
    logic [1:0] rm;
    logic [3:0] wk;   // {io, tick, sup, int}
    logic       tk;
    logic [1:0] em;
    logic       er;
    logic       ec;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b1, 2'b01, 4'h0, 1'b0, 2'b01, 1'b1, 1'b0},  // R3 go Alternate, CPU off
    '{1'b1, 2'b00, 4'h0, 1'b0, 2'b00, 1'b1, 1'b1},  // R4 back to Active
    '{1'b1, 2'b01, 4'h0, 1'b0, 2'b01, 1'b1, 1'b0},  // R4 Alternate again
    '{1'b0, 2'b00, 4'h1, 1'b0, 2'b00, 1'b1, 1'b1},  // R8 wake in Alternate
    '{1'b1, 2'b10, 4'h0, 1'b0, 2'b10, 1'b0, 1'b0},  // R4 enter Sleep
    '{1'b1, 2'b00, 4'h0, 1'b0, 2'b10, 1'b0, 1'b0},  // R5 request ignored in Sleep
    '{1'b0, 2'b00, 4'h2, 1'b0, 2'b00, 1'b0, 1'b0},  // R5 supervisor wake
    '{1'b0, 2'b00, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0}   // R7 no ticks, still waiting
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    xres = 0; wdt = 0; rv = 0; rm = 2'b00; twe = 0; tsel = 0; twd = '0;
    w_int = 0; w_sup = 0; w_tick = 0; w_io = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    idle();
    rtick = 0;
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk("R1 reset mode", mode, 2'b00);
    chk("R1 reset ready", rdy, 1);
    chk("R1 reset cpu", cpu, 1);
    chk("R1 reset sub", sub, 7'h7F);

    for (int i = 0; i < 8; i++) begin
      idle();
      rv = TBL[i].rv; rm = TBL[i].rm;
      {w_io, w_tick, w_sup, w_int} = TBL[i].wk;
      rtick = TBL[i].tk;
      cyc();
      chk($sformatf("table row %0d mode", i), mode, TBL[i].em);
      chk($sformatf("table row %0d ready", i), rdy, TBL[i].er);
      chk($sformatf("table row %0d cpu", i), cpu, TBL[i].ec);
    end

    // R7 sleep resume: 15 ticks
    idle();
    rtick = 1;
    repeat (14) cyc();
    chk("R7 sleep ready before delay", rdy, 0);
    chk("R7 sleep enables before delay", sub, 0);
    cyc();
    chk("R7 sleep ready after delay", rdy, 1);
    chk("R7 sleep mode after delay", mode, 2'b00);

    // R2 Active template write
    twe = 1; tsel = 0; twd = 8'hA5;
    cyc();
    idle();
    chk("R2 sub after write", sub, 7'h52);
    chk("R2 cpu after write", cpu, 1);
    twe = 1; twd = 8'hFE;
    cyc();
    idle();
    chk("R2 cpu cleared by firmware", cpu, 0);
    chk("R2 mode stays Active", mode, 2'b00);

    // R8 wakeup in Active re-enables the CPU
    w_tick = 1;
    cyc();
    idle();
    chk("R8 cpu on after wake", cpu, 1);

    // R3 Alternate template
    twe = 1; tsel = 1; twd = 8'h3C;
    cyc();
    idle();
    rv = 1; rm = 2'b01;
    cyc();
    idle();
    chk("R3 alt mode", mode, 2'b01);
    chk("R3 alt sub", sub, 7'h1E);
    chk("R3 alt cpu", cpu, 0);

    // R10 wake beats sleep request
    rv = 1; rm = 2'b10; w_int = 1;
    cyc();
    idle();
    chk("R10 mode Active", mode, 2'b00);
    chk("R10 ready high", rdy, 1);

    // R6 Hibernate ignores non-I/O sources
    rv = 1; rm = 2'b11;
    cyc();
    idle();
    chk("R4 hib mode", mode, 2'b11);
    chk("R4 hib enables", {sub, cpu, rdy}, 0);
    w_int = 1; cyc(); idle();
    chk("R6 int ignored", mode, 2'b11);
    w_sup = 1; cyc(); idle();
    chk("R6 sup ignored", mode, 2'b11);
    w_tick = 1; cyc(); idle();
    chk("R6 tick ignored", mode, 2'b11);
    chk("R6 still not ready", rdy, 0);

    // clear CPU bit before waking to test R8 across resume
    twe = 1; tsel = 0; twd = 8'hFE; cyc(); idle();
    w_io = 1;
    cyc();
    idle();
    chk("R6 io wakes mode", mode, 2'b00);
    chk("R7 hib ready low at wake", rdy, 0);
    for (int i = 1; i <= 98; i++) begin
      if (i == 40) begin rv = 1; rm = 2'b10; end
      cyc();
      idle();
    end
    chk("R7 hib ready before delay", rdy, 0);
    chk("R9 mode held in resume", mode, 2'b00);
    cyc();
    chk("R7 hib ready after delay", rdy, 1);
    chk("R8 cpu on after hib wake", cpu, 1);
    cyc();
    chk("R9 held request applied", mode, 2'b10);

    // R5 I/O wake from Sleep, then R1 watchdog from Sleep
    w_io = 1; cyc(); idle();
    chk("R5 io wake from sleep", mode, 2'b00);
    repeat (15) cyc();
    chk("R7 sleep io resume done", rdy, 1);
    rv = 1; rm = 2'b10; cyc(); idle();
    wdt = 1; cyc(); idle();
    chk("R1 wdt mode", mode, 2'b00);
    chk("R1 wdt ready", rdy, 1);

    // R1 external reset restores templates
    twe = 1; tsel = 0; twd = 8'h00; cyc(); idle();
    xres = 1; cyc(); idle();
    chk("R1 xres sub", sub, 7'h7F);
    chk("R1 xres cpu", cpu, 1);
    rv = 1; rm = 2'b01; cyc(); idle();
    chk("R1 alt template reset", {sub, cpu}, 8'hFC);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule